// File: doc/BRIEF.md
# 16-bit Float Dot-Product Unit

This block takes two vectors of four 16-bit floating-point numbers and returns their dot product in the same 16-bit format. A word holds one sign bit, a 6-bit biased exponent and a 9-bit fraction with an implied leading one. A caller places both vectors on the operand buses and raises `start` for one cycle. The unit then works through the lanes one after another. Each lane's significand product comes from a shift-and-add multiplier that handles one multiplier bit per clock. The product is aligned against a running sign-magnitude accumulator and added to it. A final stage normalises the sum and packs it.

The result stays on `result` until the next computation finishes. A one-cycle `done` marks each new value. Out of reset, and until the first computation completes, the result port shows the word for 30.0 (0x47C0). That is also what (1,2,3,4)·(1,2,3,4) returns. The RTL has no multiply operator: every product is built from conditional shifts and additions.

Top module: `gf16_dot4`

## Requirements
- R1: A word is decoded as sign in bit 15, exponent e in bits 14:9 and fraction f in bits 8:0, with value (-1)^s × (1 + f/512) × 2^(e−31). Lane k of each operand bus occupies bits 16k+15 down to 16k.
- R2: Any operand whose exponent field is zero counts as zero, whatever its fraction bits hold.
- R3: When no nonzero bit is shifted out during alignment, the result is the exact dot product truncated toward zero to 9 fraction bits. This holds for mixed signs and for terms whose exponents differ widely. Bits that are shifted below the accumulator's least significant position during alignment are discarded.
- R4: The vectors (1,2,3,4) and (1,2,3,4) give 0x47C0.
- R5: While reset is low, and afterwards until the first `done`, `result` equals 0x47C0 and `done` is low.
- R6: `done` is high for exactly one cycle, 45 clock edges after the edge that accepts `start`. `result` changes only in the cycle where `done` is high.
- R7: A `start` that arrives while a computation is in progress is ignored. It neither changes the pending result nor produces an extra `done`.
- R8: A result whose unbiased exponent would exceed 32 saturates to the largest finite magnitude with the sum's sign: 0x7FFF or 0xFFFF.
- R9: A result whose biased exponent would be zero or below becomes a zero carrying the sum's sign (0x0000 or 0x8000). An exact cancellation returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request; captures both operand buses |
| a_vec | input | 64 | First vector, lane k in bits 16k+15:16k |
| b_vec | input | 64 | Second vector, same lane layout |
| result | output | 16 | Packed dot product, or 0x47C0 before the first result |
| done | output | 1 | One-cycle strobe marking a new `result` |

## Verification
Two things can happen in the same cycle: a new `start` request, and a computation that is still running and owns the multiplier and accumulator. The bench provokes this by raising `start` again, with different operands, ten cycles into a computation. It then requires that the result matches the first vector pair, that the latency is still 45 edges, and that no second `done` follows within the next sixty cycles. Around this, an exhaustive sweep over small integer vectors and a seeded sweep with mixed signs compare the result against a real-number model of the dot product.

// File: rtl/gf16_dot4.sv
module gf16_dot4 #(
  parameter int LANES = 4,
  parameter int EXP_W = 6,
  parameter int MAN_W = 9,
  parameter logic [EXP_W+MAN_W:0] RESET_WORD = 16'h47C0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [LANES*(1+EXP_W+MAN_W)-1:0] a_vec,
  input  logic [LANES*(1+EXP_W+MAN_W)-1:0] b_vec,
  output logic [EXP_W+MAN_W:0]           result,
  output logic                           done
);
  localparam int W    = 1 + EXP_W + MAN_W;
  localparam int SIG  = MAN_W + 1;
  localparam int PW   = 2 * SIG;
  localparam int FR   = 2 * MAN_W;
  localparam int AW   = PW + $clog2(LANES) + 1;
  localparam int LW   = $clog2(LANES);
  localparam int CW   = $clog2(SIG + 1);
  localparam int XW   = EXP_W + 4;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX = (1 << EXP_W) - 1;

  typedef enum logic [1:0] {IDLE, MUL, ADD, FIN} st_t;
  st_t state;

  logic [LANES*W-1:0]    a_q, b_q;
  logic [LW-1:0]         lane;
  logic [CW-1:0]         cnt;
  logic [PW-1:0]         mcand, prod;
  logic [SIG-1:0]        mplier;
  logic                  psign, acc_s;
  logic signed [XW-1:0]  pexp, acc_e;
  logic [AW-1:0]         acc_m;

  function automatic logic [SIG-1:0] sig_of(input logic [W-1:0] x);
    return (x[W-2:MAN_W] == '0) ? '0 : {1'b1, x[MAN_W-1:0]};
  endfunction

  function automatic logic signed [XW-1:0] ex(input logic [EXP_W-1:0] e);
    return signed'({{(XW-EXP_W){1'b0}}, e});
  endfunction

  wire [LW-1:0] nl  = (state == IDLE) ? '0 : lane + 1'b1;
  wire [W-1:0]  opa = (state == IDLE) ? a_vec[W-1:0] : a_q[nl*W +: W];
  wire [W-1:0]  opb = (state == IDLE) ? b_vec[W-1:0] : b_q[nl*W +: W];

  // alignment and sign-magnitude add
  logic [AW-1:0]        n_m, am, bm;
  logic signed [XW-1:0] n_e, diff;
  logic                 n_s;
  always_comb begin
    diff = acc_e - pexp;
    n_m = acc_m; n_e = acc_e; n_s = acc_s;
    am = '0; bm = '0;
    if (acc_m == '0) begin
      n_m = AW'(prod); n_e = pexp; n_s = psign;
    end else if (prod != '0) begin
      if (diff >= 0) begin
        n_e = acc_e; am = acc_m;
        bm = (diff >= AW) ? '0 : AW'(prod) >> diff;
      end else begin
        n_e = pexp; bm = AW'(prod);
        am = (-diff >= AW) ? '0 : acc_m >> (-diff);
      end
      if (acc_s == psign) begin
        n_m = am + bm; n_s = acc_s;
      end else if (am >= bm) begin
        n_m = am - bm; n_s = acc_s;
      end else begin
        n_m = bm - am; n_s = psign;
      end
      if (n_m == '0) n_s = 1'b0;
    end
  end

  // normalise and pack, truncating
  int            lead, fexp;
  logic [AW-1:0] shl;
  logic [W-1:0]  packed_w;
  always_comb begin
    lead = 0;
    for (int i = 0; i < AW; i++) if (acc_m[i]) lead = i;
    shl  = acc_m << (AW - 1 - lead);
    fexp = int'(acc_e) + lead - FR;
    if (acc_m == '0)       packed_w = '0;
    else if (fexp <= 0)    packed_w = {acc_s, {(W-1){1'b0}}};
    else if (fexp > EMAX)  packed_w = {acc_s, {(W-1){1'b1}}};
    else                   packed_w = {acc_s, EXP_W'(fexp), shl[AW-2 -: MAN_W]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE; result <= RESET_WORD; done <= 1'b0;
      a_q <= '0; b_q <= '0; lane <= '0; cnt <= '0;
      mcand <= '0; prod <= '0; mplier <= '0; psign <= 1'b0; pexp <= '0;
      acc_m <= '0; acc_e <= '0; acc_s <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        IDLE: if (start) begin
          a_q <= a_vec; b_q <= b_vec; lane <= '0;
          acc_m <= '0; acc_e <= '0; acc_s <= 1'b0;
          state <= MUL;
        end
        MUL: begin
          if (mplier[0]) prod <= prod + mcand;
          mcand  <= mcand << 1;
          mplier <= mplier >> 1;
          cnt    <= cnt + 1'b1;
          if (cnt == CW'(SIG - 1)) state <= ADD;
        end
        ADD: begin
          acc_m <= n_m; acc_e <= n_e; acc_s <= n_s;
          if (lane == LW'(LANES - 1)) state <= FIN;
          else begin lane <= nl; state <= MUL; end
        end
        FIN: begin
          result <= packed_w; done <= 1'b1; state <= IDLE;
        end
        default: state <= IDLE;
      endcase
      if ((state == IDLE && start) || (state == ADD && lane != LW'(LANES - 1))) begin
        mcand  <= PW'(sig_of(opa));
        mplier <= sig_of(opb);
        prod   <= '0;
        cnt    <= '0;
        psign  <= opa[W-1] ^ opb[W-1];
        pexp   <= ex(opa[W-2:MAN_W]) + ex(opb[W-2:MAN_W]) - signed'(XW'(BIAS));
      end
    end
  end
endmodule

// File: rtl/gf16_dot4_chk.sv
module gf16_dot4_chk #(
  parameter int W = 16,
  parameter int EXP_W = 6,
  parameter int MAN_W = 9,
  parameter int LAT = 45,
  parameter logic [W-1:0] RESET_WORD = '0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result
);
  logic seen, run;
  int   cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0; run <= 1'b0; cyc <= 0;
    end else begin
      if (done) seen <= 1'b1;
      if (start && !busy) begin run <= 1'b1; cyc <= 0; end
      else if (done) run <= 1'b0;
      else if (run) cyc <= cyc + 1;
    end
  end

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);
  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run && cyc == LAT));
  assert_reset_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen && !done) |-> result == RESET_WORD);
  assert_zero_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result[W-2:MAN_W] == '0) |-> result[MAN_W-1:0] == '0);
endmodule

bind gf16_dot4 gf16_dot4_chk #(
  .W(W), .EXP_W(EXP_W), .MAN_W(MAN_W),
  .LAT(LANES * (MAN_W + 2) + 1), .RESET_WORD(RESET_WORD)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(state != IDLE),
  .done(done), .result(result)
);

// File: tb/gf16_dot4_tb.sv
module gf16_dot4_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [63:0] a_vec = '0, b_vec = '0;
  logic [15:0] result;
  logic        done;
  int tests = 0, fails = 0;
  logic [31:0] seed = 32'h1357_9bdf;

  gf16_dot4 dut_i (.clk(clk), .rst_n(rst_n), .start(start), .a_vec(a_vec),
                   .b_vec(b_vec), .result(result), .done(done));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] enc(input real r);
    logic s; real m; int e;
    if (r == 0.0) return 16'h0000;
    s = (r < 0.0); m = s ? -r : r; e = 31;
    while (m >= 2.0) begin m = m / 2.0; e++; end
    while (m < 1.0)  begin m = m * 2.0; e--; end
    if (e <= 0) return {s, 15'h0000};
    if (e > 63) return {s, 15'h7FFF};
    return {s, 6'(e), 9'($rtoi((m - 1.0) * 512.0))};
  endfunction

  function automatic logic [15:0] ei(input int n);
    return enc(real'(n));
  endfunction

  function automatic real dec(input logic [15:0] x);
    real v; int e;
    if (x[14:9] == 6'd0) return 0.0;
    v = 1.0 + real'(x[8:0]) / 512.0;
    e = int'(x[14:9]) - 31;
    while (e > 0) begin v = v * 2.0; e--; end
    while (e < 0) begin v = v / 2.0; e++; end
    return x[15] ? -v : v;
  endfunction

  function automatic logic [63:0] pk(input logic [15:0] w0, w1, w2, w3);
    return {w3, w2, w1, w0};
  endfunction

  function automatic real dot(input logic [63:0] a, b);
    real s = 0.0;
    for (int k = 0; k < 4; k++) s += dec(a[k*16 +: 16]) * dec(b[k*16 +: 16]);
    return s;
  endfunction

  function automatic logic [15:0] rw();
    seed = seed * 32'd1103515245 + 32'd12345;
    return {seed[31], 6'(24 + seed[20:16] % 15), seed[12:4]};
  endfunction

  task automatic run(input logic [63:0] a, input logic [63:0] b,
                     output logic [15:0] res, output int lat);
    @(negedge clk); a_vec = a; b_vec = b; start = 1'b1;
    @(negedge clk); start = 1'b0; lat = 0;
    do begin @(negedge clk); lat++; end while (!done && lat < 200);
    res = result;
  endtask

  task automatic exact(input logic [63:0] a, input logic [63:0] b, input string req);
    logic [15:0] r; int lat; logic [15:0] e;
    e = enc(dot(a, b));
    run(a, b, r, lat);
    chk(r == e, req, r, e);
  endtask

  initial begin
    #400_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] r; int lat; logic [63:0] a, b; real m, g, tol, mx;
    repeat (3) @(negedge clk);
    chk(result == 16'h47C0, "R5 in reset", result, 16'h47C0);
    chk(done == 1'b0, "R5 done in reset", done, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(result == 16'h47C0, "R5 after reset", result, 16'h47C0);

    // R4 canonical vector, R6 latency and pulse width
    a = pk(ei(1), ei(2), ei(3), ei(4));
    run(a, a, r, lat);
    chk(r == 16'h47C0, "R4 canonical", r, 16'h47C0);
    chk(lat == 45, "R6 latency", lat, 45);
    @(negedge clk);
    chk(done == 1'b0, "R6 single pulse", done, 0);
    chk(result == 16'h47C0, "R6 hold", result, 16'h47C0);

    // R2 zero exponent flushes the lane
    exact(pk(16'h01FF, ei(2), ei(3), ei(4)), pk(ei(5), ei(2), ei(3), ei(4)), "R2 flush");
    chk(result == ei(29), "R2 flush value", result, ei(29));

    // R8 saturation, both signs
    exact(pk(16'h7E00, 0, 0, 0), pk(16'h7E00, 0, 0, 0), "R8 sat pos");
    chk(result == 16'h7FFF, "R8 sat pos word", result, 16'h7FFF);
    exact(pk(16'hFE00, 0, 0, 0), pk(16'h7E00, 0, 0, 0), "R8 sat neg");
    chk(result == 16'hFFFF, "R8 sat neg word", result, 16'hFFFF);

    // R9 underflow to signed zero, and exact cancellation
    exact(pk(16'h0200, 0, 0, 0), pk(16'h0200, 0, 0, 0), "R9 underflow pos");
    chk(result == 16'h0000, "R9 underflow pos word", result, 16'h0000);
    exact(pk(16'h8200, 0, 0, 0), pk(16'h0200, 0, 0, 0), "R9 underflow neg");
    chk(result == 16'h8000, "R9 underflow neg word", result, 16'h8000);
    exact(pk(ei(3), ei(3), ei(7), ei(7)), pk(ei(5), ei(-5), ei(2), ei(-2)), "R9 cancel");
    chk(result == 16'h0000, "R9 cancel word", result, 16'h0000);

    // R3 wide exponent differences
    exact(pk(ei(1 << 20), ei(1), 0, 0), pk(ei(1), ei(1), 0, 0), "R3 wide add");
    chk(result == 16'h6600, "R3 wide add word", result, 16'h6600);
    exact(pk(ei(1 << 20), ei(-(1 << 12)), 0, 0), pk(ei(1), ei(1), 0, 0), "R3 wide sub");

    // R7 start during a computation is ignored
    a = pk(ei(2), ei(-3), ei(5), ei(1)); b = pk(ei(7), ei(4), ei(1), ei(9));
    @(negedge clk); a_vec = a; b_vec = b; start = 1'b1;
    @(negedge clk); start = 1'b0; lat = 0;
    repeat (9) begin @(negedge clk); lat++; end
    a_vec = pk(ei(100), ei(100), 0, 0); b_vec = a_vec; start = 1'b1;
    @(negedge clk); lat++; start = 1'b0;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
    chk(result == enc(dot(a, b)), "R7 result kept", result, enc(dot(a, b)));
    chk(lat == 45, "R7 latency kept", lat, 45);
    begin
      int extra = 0;
      repeat (60) begin @(negedge clk); if (done) extra++; end
      chk(extra == 0, "R7 no extra done", extra, 0);
    end

    // R1 R3 exhaustive small-integer sweep with mixed signs
    for (int i = 1; i <= 16; i++)
      for (int j = 1; j <= 16; j++)
        exact(pk(ei(i), ei(-(17 - i)), ei(3), ei(j)),
              pk(ei(j), ei(j), ei(5), ei(-2)), "R1 R3 integer sweep");

    // R3 seeded sweep against the real model with a truncation tolerance
    for (int n = 0; n < 200; n++) begin
      a = pk(rw(), rw(), rw(), rw()); b = pk(rw(), rw(), rw(), rw());
      m = dot(a, b); mx = 0.0;
      for (int k = 0; k < 4; k++) begin
        g = dec(a[k*16 +: 16]) * dec(b[k*16 +: 16]);
        if (g < 0.0) g = -g;
        if (g > mx) mx = g;
      end
      run(a, b, r, lat);
      g = dec(r) - m; if (g < 0.0) g = -g;
      tol = (m < 0.0 ? -m : m) / 256.0 + mx / 32768.0;
      chk(g <= tol, "R3 seeded sweep", r, enc(m));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule